// File: doc/BRIEF.md
# Program Counter and Circular Subroutine Stack Controller

This block owns the program counter and a 3-bit return-stack pointer, and it keeps four status bits that travel with the pointer in the status word. Subroutine calls and interrupts save the current counter, together with the four status bits, as a byte pair in general-purpose data RAM. Each save takes two RAM write cycles. Returns read the pair back in two RAM read cycles. The stack holds eight entries at addresses 8 to 23, and entry n sits at 8+2n (even byte) and 9+2n (odd byte). The pointer wraps silently in both directions: a ninth nested call overwrites the oldest entry, and a return from an empty stack reads the entry at the top of the ring.

The instruction decoder drives one-cycle command pulses, a jump target and a single-step request. The RAM array is outside the block. It is reached through a write strobe, a read strobe, an address, write data and read data. Read data is expected one cycle after the read strobe. The top counter bits are only passed through on the PC output, where the fetch logic uses them to tell internal program space from external program space.

Top module: `pc_stack_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the PC, stack pointer and status bits are zero, busy is low, and neither RAM strobe is active.
- R2: A call or interrupt accepted while idle performs two RAM writes on consecutive cycles, starting the cycle after the command. The first write goes to address 8+2*sp with data PC[7:0]. The second goes to 9+2*sp with data {status[3:0], PC[11:8]}.
- R3: When the second write completes, the stack pointer increments and the PC loads the jump target for a call, or the fixed vector 0x003 for an interrupt. Busy is high during both write cycles.
- R4: A return accepted while idle first decrements the pointer. It then reads address 8+2*sp and then 9+2*sp, and loads the PC from the two bytes (low byte from the even address, PC[11:8] from the low nibble of the odd address). A plain return leaves the status bits unchanged.
- R5: A return-with-restore behaves like a return and also loads the status bits from the upper nibble of the odd byte.
- R6: The pointer wraps from 7 to 0 on a push and from 0 to 7 on a pop. A ninth nested call overwrites addresses 8 and 9.
- R7: Commands, steps and status writes are ignored while busy. When several commands arrive together while idle, interrupt wins over call, call over return-with-restore, and that over return.
- R8: A step request while idle with no command increments the PC by one, modulo 4096.
- R9: A status write while idle with no command loads the four status bits.
- R10: The two RAM strobes are never active together, and every access lies in addresses 8 to 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| do_call | input | 1 | Subroutine call command |
| do_intr | input | 1 | Interrupt entry command |
| do_ret | input | 1 | Return, PC only |
| do_retr | input | 1 | Return with status restore |
| pc_step | input | 1 | Advance PC by one |
| jmp_tgt | input | 12 | Call target address |
| st_we | input | 1 | Status bits write enable |
| st_wd | input | 4 | Status bits write data |
| ram_we | output | 1 | Data RAM write strobe |
| ram_re | output | 1 | Data RAM read strobe |
| ram_addr | output | 8 | Data RAM address |
| ram_wdata | output | 8 | Data RAM write data |
| ram_rdata | input | 8 | Data RAM read data, valid one cycle after ram_re |
| pc_o | output | 12 | Program counter |
| sp_o | output | 3 | Stack pointer |
| st_o | output | 4 | Status bits |
| busy | output | 1 | Push or pop sequence in progress |

## Verification
The assertions assume the RAM returns read data exactly one cycle after the read strobe. They also assume command inputs are only interpreted while busy is low, so a step request is checked only in an idle cycle with no command present. The bench keeps to these assumptions with a registered RAM model of one-cycle latency. It issues each command as a one-cycle pulse and waits for busy to drop before issuing the next. The exception is the deliberate overlap case, where commands are raised during a busy window to show they are ignored.

// File: rtl/pc_stack_ctrl.sv
module pc_stack_ctrl #(
  parameter int PC_W       = 12,
  parameter int SP_W       = 3,
  parameter int ST_W       = 4,
  parameter int AW         = 8,
  parameter int STACK_BASE = 8,
  parameter int INTR_VEC   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            do_call,
  input  logic            do_intr,
  input  logic            do_ret,
  input  logic            do_retr,
  input  logic            pc_step,
  input  logic [PC_W-1:0] jmp_tgt,
  input  logic            st_we,
  input  logic [ST_W-1:0] st_wd,
  output logic            ram_we,
  output logic            ram_re,
  output logic [AW-1:0]   ram_addr,
  output logic [7:0]      ram_wdata,
  input  logic [7:0]      ram_rdata,
  output logic [PC_W-1:0] pc_o,
  output logic [SP_W-1:0] sp_o,
  output logic [ST_W-1:0] st_o,
  output logic            busy
);
  localparam int DW   = 8;
  localparam int HI_W = PC_W - DW;

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_RLO, S_RHI, S_RFIN} state_t;

  state_t            state;
  logic [PC_W-1:0]   pc, tgt;
  logic [SP_W-1:0]   sp;
  logic [ST_W-1:0]   st;
  logic [DW-1:0]     lo_byte;
  logic              restore;
  logic              go_push, go_pop, odd;
  logic [AW-1:0]     slot;

  assign go_push = do_intr | do_call;
  assign go_pop  = do_retr | do_ret;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pc      <= '0;
      tgt     <= '0;
      sp      <= '0;
      st      <= '0;
      lo_byte <= '0;
      restore <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (go_push) begin
            tgt   <= do_intr ? PC_W'(INTR_VEC) : jmp_tgt;
            state <= S_WLO;
          end else if (go_pop) begin
            sp      <= sp - 1'b1;
            restore <= do_retr;
            state   <= S_RLO;
          end else begin
            if (pc_step) pc <= pc + 1'b1;
            if (st_we)   st <= st_wd;
          end
        end
        S_WLO: state <= S_WHI;
        S_WHI: begin
          sp    <= sp + 1'b1;
          pc    <= tgt;
          state <= S_IDLE;
        end
        S_RLO: state <= S_RHI;
        S_RHI: begin
          lo_byte <= ram_rdata;
          state   <= S_RFIN;
        end
        S_RFIN: begin
          pc <= {ram_rdata[HI_W-1:0], lo_byte};
          if (restore) st <= ram_rdata[DW-1 -: ST_W];
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign odd       = (state == S_WHI) || (state == S_RHI);
  assign slot      = AW'(STACK_BASE) + AW'({sp, 1'b0});
  assign ram_we    = (state == S_WLO) || (state == S_WHI);
  assign ram_re    = (state == S_RLO) || (state == S_RHI);
  assign ram_addr  = (ram_we || ram_re) ? (slot | AW'(odd)) : '0;
  assign ram_wdata = (state == S_WHI) ? {st, pc[PC_W-1:DW]} : pc[DW-1:0];
  assign pc_o      = pc;
  assign sp_o      = sp;
  assign st_o      = st;
  assign busy      = (state != S_IDLE);
endmodule

// File: rtl/pc_stack_chk.sv
module pc_stack_chk #(
  parameter int PC_W       = 12,
  parameter int SP_W       = 3,
  parameter int ST_W       = 4,
  parameter int AW         = 8,
  parameter int STACK_BASE = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            do_call,
  input logic            do_intr,
  input logic            do_ret,
  input logic            do_retr,
  input logic            pc_step,
  input logic            ram_we,
  input logic            ram_re,
  input logic [AW-1:0]   ram_addr,
  input logic [PC_W-1:0] pc_o,
  input logic [SP_W-1:0] sp_o,
  input logic [ST_W-1:0] st_o,
  input logic            busy
);
  localparam int TOP = STACK_BASE + 2 * (2 ** SP_W) - 1;

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (pc_o == '0 && sp_o == '0 && st_o == '0 && !busy && !ram_we && !ram_re));

  assert_push_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !ram_addr[0]) |=> (ram_we && ram_addr == AW'($past(ram_addr) + 1)));

  assert_push_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_addr[0]) |=> (!busy && sp_o == SP_W'($past(sp_o) + 1)));

  assert_pop_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_re && !ram_addr[0]) |=> (ram_re && ram_addr == AW'($past(ram_addr) + 1)));

  assert_pop_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !do_intr && !do_call && (do_ret || do_retr)) |=> (sp_o == SP_W'($past(sp_o) - 1)));

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ram_we) |=> $stable(st_o) || !busy);

  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pc_step && !do_call && !do_intr && !do_ret && !do_retr) |=> (pc_o == PC_W'($past(pc_o) + 1)));

  assert_no_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));

  assert_addr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re) |-> (ram_addr >= AW'(STACK_BASE) && ram_addr <= AW'(TOP)));
endmodule

bind pc_stack_ctrl pc_stack_chk #(
  .PC_W(PC_W), .SP_W(SP_W), .ST_W(ST_W), .AW(AW), .STACK_BASE(STACK_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .do_call(do_call), .do_intr(do_intr), .do_ret(do_ret),
  .do_retr(do_retr), .pc_step(pc_step), .ram_we(ram_we), .ram_re(ram_re),
  .ram_addr(ram_addr), .pc_o(pc_o), .sp_o(sp_o), .st_o(st_o), .busy(busy)
);

// File: tb/sim_pc_stack_ctrl.sv
module sim_pc_stack_ctrl;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        do_call = 0, do_intr = 0, do_ret = 0, do_retr = 0, pc_step = 0, st_we = 0;
  logic [11:0] jmp_tgt = '0;
  logic [3:0]  st_wd = '0;
  logic        ram_we, ram_re, busy;
  logic [7:0]  ram_addr, ram_wdata;
  logic [7:0]  ram_rdata = '0;
  logic [11:0] pc_o;
  logic [2:0]  sp_o;
  logic [3:0]  st_o;
  logic [7:0]  mem [256];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  pc_stack_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .do_call(do_call), .do_intr(do_intr), .do_ret(do_ret),
    .do_retr(do_retr), .pc_step(pc_step), .jmp_tgt(jmp_tgt), .st_we(st_we), .st_wd(st_wd),
    .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .pc_o(pc_o), .sp_o(sp_o), .st_o(st_o), .busy(busy)
  );

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  // op codes: 0 step, 1 call, 2 intr, 3 ret, 4 retr, 5 status write
  // fields: op[33:31] arg[30:19] exp_pc[18:7] exp_sp[6:4] exp_st[3:0]
  localparam logic [33:0] VEC [0:10] = '{
    {3'd0, 12'h000, 12'h001, 3'd0, 4'h0},
    {3'd5, 12'h00A, 12'h001, 3'd0, 4'hA},
    {3'd1, 12'h123, 12'h123, 3'd1, 4'hA},
    {3'd0, 12'h000, 12'h124, 3'd1, 4'hA},
    {3'd2, 12'h000, 12'h003, 3'd2, 4'hA},
    {3'd5, 12'h005, 12'h003, 3'd2, 4'h5},
    {3'd4, 12'h000, 12'h124, 3'd1, 4'hA},
    {3'd3, 12'h000, 12'h001, 3'd0, 4'hA},
    {3'd1, 12'hFFF, 12'hFFF, 3'd1, 4'hA},
    {3'd0, 12'h000, 12'h000, 3'd1, 4'hA},
    {3'd3, 12'h000, 12'h001, 3'd0, 4'hA}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input int op, input logic [11:0] arg);
    do_call = (op == 1); do_intr = (op == 2); do_ret = (op == 3);
    do_retr = (op == 4); pc_step = (op == 0); st_we = (op == 5);
    jmp_tgt = arg; st_wd = arg[3:0];
  endtask

  task automatic quiet();
    do_call = 0; do_intr = 0; do_ret = 0; do_retr = 0; pc_step = 0; st_we = 0;
  endtask

  task automatic run_op(input int op, input logic [11:0] arg);
    @(negedge clk); drive(op, arg);
    @(negedge clk); quiet();
    while (busy) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; quiet();
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    do_reset();
    // R1 reset state
    chk(pc_o, 0, "R1 pc"); chk(sp_o, 0, "R1 sp"); chk(st_o, 0, "R1 status");
    chk(busy, 0, "R1 busy"); chk({ram_we, ram_re}, 0, "R1 strobes");

    // table: R3 R4 R5 R8 R9
    for (int i = 0; i < 11; i++) begin
      run_op(int'(VEC[i][33:31]), VEC[i][30:19]);
      chk(pc_o, VEC[i][18:7], $sformatf("R3/R4/R5/R8/R9 vec%0d pc", i));
      chk(sp_o, VEC[i][6:4],  $sformatf("R3/R4/R6 vec%0d sp", i));
      chk(st_o, VEC[i][3:0],  $sformatf("R5/R9 vec%0d status", i));
    end

    // R2 write sequence timing and data
    do_reset();
    run_op(5, 12'h009);
    @(negedge clk); drive(1, 12'h040);
    @(negedge clk); quiet();
    chk({ram_we, ram_re, busy}, 3'b101, "R2 first write strobes");
    chk(ram_addr, 8, "R2 first write addr"); chk(ram_wdata, 8'h00, "R2 first write data");
    @(negedge clk);
    chk(ram_we, 1, "R2 second write strobe");
    chk(ram_addr, 9, "R2 second write addr"); chk(ram_wdata, 8'h90, "R2 second write data");
    @(negedge clk);
    chk(busy, 0, "R3 busy end"); chk(pc_o, 12'h040, "R3 pc target"); chk(sp_o, 1, "R3 sp");

    // R4 read sequence; plain return keeps status
    run_op(5, 12'h003);
    @(negedge clk); drive(3, 12'h000);
    @(negedge clk); quiet();
    chk({ram_re, ram_we}, 2'b10, "R4 first read strobe");
    chk(ram_addr, 8, "R4 first read addr"); chk(sp_o, 0, "R4 sp decremented first");
    @(negedge clk);
    chk(ram_addr, 9, "R4 second read addr");
    while (busy) @(negedge clk);
    chk(pc_o, 12'h000, "R4 pc restored"); chk(st_o, 4'h3, "R4 status kept");

    // R6 underflow from empty stack with restore
    do_reset();
    mem[22] = 8'h5A; mem[23] = 8'hC3;
    run_op(4, 12'h000);
    chk(sp_o, 7, "R6 underflow sp"); chk(pc_o, 12'h35A, "R6/R5 underflow pc");
    chk(st_o, 4'hC, "R5 restored status");

    // R6 overflow: nine nested calls
    do_reset();
    for (int i = 0; i < 9; i++) run_op(1, 12'h100 + 12'(i));
    chk(sp_o, 1, "R6 overflow sp");
    chk(mem[8], 8'h07, "R6 overwritten low byte"); chk(mem[9], 8'h01, "R6 overwritten high byte");
    run_op(3, 12'h000);
    chk(pc_o, 12'h107, "R6 pop wrapped entry pc"); chk(sp_o, 0, "R6 pop sp");
    run_op(3, 12'h000);
    chk(pc_o, 12'h106, "R6 pop entry 7 pc"); chk(sp_o, 7, "R6 pop wrap sp");

    // R7 commands while busy are ignored; priority while idle
    do_reset();
    @(negedge clk); drive(1, 12'h200);
    @(negedge clk); quiet(); do_ret = 1; pc_step = 1; st_we = 1; st_wd = 4'hF;
    @(negedge clk); quiet();
    while (busy) @(negedge clk);
    chk(pc_o, 12'h200, "R7 busy ignore pc"); chk(sp_o, 1, "R7 busy ignore sp");
    chk(st_o, 0, "R7 busy ignore status");
    @(negedge clk); drive(1, 12'h300); do_intr = 1; do_ret = 1; do_retr = 1;
    @(negedge clk); quiet();
    while (busy) @(negedge clk);
    chk(pc_o, 12'h003, "R7 intr wins pc"); chk(sp_o, 2, "R7 intr wins sp");
    chk({mem[11], mem[10]}, 16'h0200, "R7 saved pc at entry 1");
    @(negedge clk); drive(1, 12'h0AB); do_ret = 1;
    @(negedge clk); quiet();
    while (busy) @(negedge clk);
    chk(pc_o, 12'h0AB, "R7 call over return pc"); chk(sp_o, 3, "R7 call over return sp");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule